// File: doc/BRIEF.md
# Modular Fibonacci Word Scrambler Link

This block whitens a stream of 16-bit words for a twisted-pair line. A two-register additive generator, reduced modulo a non-binary modulus just under three times 65536, produces one key value per word. The key is added to the data word under the same modulus. The result fits in 18 bits and becomes the line symbol. Its top two bits form a header, and that header can never be 11. The pattern 11 is therefore free for control and framing symbols. A control symbol carries its 16-bit code in clear, and the generator does not step for it.

The top holds a transmit half and a receive half. Each half has its own copy of the generator, and both copies start from the same seed. The transmit half turns accepted words into symbols. The receive half takes symbols and subtracts its own key to give back the words. The two halves stay in lockstep because both step once per data symbol and never for a control symbol. The residue reduction costs a second clock cycle per step. For that reason the transmit side accepts at most one data word every two cycles.

Keys and symbols are kept in the residue range 1..M and never 0..M-1. This choice means that a data symbol can never be all zeros. Because the value stays below 196608, a data symbol also can never be all ones. The modulus parameter takes 196598 (the default) or 196594.

Top module: `gfs_link`

## Requirements
- R1: While reset is high, and in the first cycle after it, tx_ready is 1 and sym_valid and rx_valid are 0. Reset loads the generators with X = SEED_X, Y = SEED_Y and carry = 0.
- R2: Each generator step forms t = X + Y + carry. If t > M, Y takes t - M and carry takes 1. Otherwise Y takes t and carry takes 0. In both cases X takes the old Y. The generator steps once per accepted data word and at no other time.
- R3: A data word w accepted at a clock edge yields, after that same edge, sym_out = w + Y if that sum is ≤ M, and w + Y - M otherwise. Here Y is the value before the step. sym_out[17:16] is the header and sym_out[15:0] is the body.
- R4: A data symbol never has header 11. It is never all zeros and never all ones.
- R5: A word accepted with tx_ctrl = 1 yields sym_out = {2'b11, code} and does not step the generator.
- R6: After a data word is accepted, tx_ready is 0 for exactly one cycle, and a valid word offered in that cycle is not taken. Accepting a control word leaves tx_ready at 1.
- R7: sym_valid is 1 for exactly the cycle after each acceptance and 0 otherwise.
- R8: A data symbol received on rx_sym gives rx_valid = 1, rx_ctrl = 0 and rx_word equal to the original word one cycle later. A cycle without rx_sym_valid gives rx_valid = 0 one cycle later.
- R9: A received symbol with header 11 gives rx_valid = 1, rx_ctrl = 1 and rx_word equal to its body one cycle later, and it does not step the receive generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Word can be taken this cycle |
| tx_ctrl | input | 1 | Offered word is a control code |
| tx_word | input | 16 | Data word or control code |
| sym_valid | output | 1 | Symbol present on sym_out |
| sym_out | output | 18 | Line symbol: header and body |
| rx_sym_valid | input | 1 | Received symbol present |
| rx_sym | input | 18 | Received line symbol |
| rx_valid | output | 1 | Recovered word present |
| rx_ctrl | output | 1 | Recovered word is a control code |
| rx_word | output | 16 | Recovered data word or control code |

## Verification
The transmit symbols are compared with a reference generator in the bench. Three kinds of input drive the comparison: random data words, the extreme words 0x0000 and 0xFFFF, and words chosen so that word + Y lands exactly on M and on M + 1. These separate an off-by-one in the reduction from a wrong residue range. Control words placed between data words show whether the generator wrongly steps on control symbols: the symbols and recovered words that follow would go out of step. Words held valid through the busy cycle, and idle gaps, show whether the handshake or the step count is wrong.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
    localparam int WORD_W = 16;
    localparam int HDR_W  = 2;
    localparam int SYM_W  = WORD_W + HDR_W;
    localparam int SUM_W  = SYM_W + 1;

    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b11;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SYM_W-1:0]  res_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        word_t            body;
    } sym_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_FOLD = 1'b1
    } phase_e;

    // t lies in 1..2m; result lies in 1..m
    function automatic res_t fold(input sum_t t, input sum_t m);
        sum_t d;
        d = (t > m) ? (t - m) : t;
        return d[SYM_W-1:0];
    endfunction

    function automatic res_t res_add(input res_t y, input word_t w, input sum_t m);
        return fold(sum_t'(y) + sum_t'(w), m);
    endfunction

    function automatic word_t res_sub(input res_t s, input res_t y, input sum_t m);
        sum_t d;
        if (s >= y) d = sum_t'(s) - sum_t'(y);
        else        d = sum_t'(s) + m - sum_t'(y);
        return d[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/gfs_gen.sv
module gfs_gen
    import gfs_pkg::*;
#(
    parameter int unsigned MODULUS = 196598,
    parameter int unsigned SEED_X  = 1,
    parameter int unsigned SEED_Y  = 70001
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output res_t key,
    output logic busy
);
    localparam sum_t MOD = sum_t'(MODULUS);

    res_t   x_q;
    res_t   y_q;
    logic   c_q;
    sum_t   t_q;
    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q  <= res_t'(SEED_X);
            y_q  <= res_t'(SEED_Y);
            c_q  <= 1'b0;
            t_q  <= '0;
            ph_q <= PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (advance) begin
                        t_q  <= sum_t'(x_q) + sum_t'(y_q) + sum_t'(c_q);
                        ph_q <= PH_FOLD;
                    end
                end
                PH_FOLD: begin
                    x_q  <= y_q;
                    y_q  <= fold(t_q, MOD);
                    c_q  <= (t_q > MOD);
                    ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign key  = y_q;
    assign busy = (ph_q == PH_FOLD);
endmodule

// File: rtl/gfs_tx.sv
module gfs_tx
    import gfs_pkg::*;
#(
    parameter int unsigned MODULUS = 196598,
    parameter int unsigned SEED_X  = 1,
    parameter int unsigned SEED_Y  = 70001
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_ctrl,
    input  word_t in_word,
    output logic  in_ready,
    output logic  out_valid,
    output res_t  out_sym
);
    localparam sum_t MOD = sum_t'(MODULUS);

    res_t key;
    logic busy;
    logic take;
    logic take_data;
    sym_t sym_d;

    assign in_ready  = !busy;
    assign take      = in_valid && !busy;
    assign take_data = take && !in_ctrl;

    gfs_gen #(
        .MODULUS(MODULUS),
        .SEED_X (SEED_X),
        .SEED_Y (SEED_Y)
    ) u_gen (
        .clk    (clk),
        .rst    (rst),
        .advance(take_data),
        .key    (key),
        .busy   (busy)
    );

    always_comb begin
        if (in_ctrl) begin
            sym_d.hdr  = HDR_CTRL;
            sym_d.body = in_word;
        end else begin
            sym_d = sym_t'(res_add(key, in_word, MOD));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= take;
            if (take) out_sym <= sym_d;
        end
    end
endmodule

// File: rtl/gfs_rx.sv
module gfs_rx
    import gfs_pkg::*;
#(
    parameter int unsigned MODULUS = 196598,
    parameter int unsigned SEED_X  = 1,
    parameter int unsigned SEED_Y  = 70001
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  res_t  in_sym,
    output logic  out_valid,
    output logic  out_ctrl,
    output word_t out_word
);
    localparam sum_t MOD = sum_t'(MODULUS);

    sym_t s;
    res_t key;
    logic busy;
    logic is_ctrl;
    logic take;
    logic take_data;

    assign s         = sym_t'(in_sym);
    assign is_ctrl   = (s.hdr == HDR_CTRL);
    // a data symbol landing in the fold cycle cannot be keyed and is dropped
    assign take      = in_valid && (is_ctrl || !busy);
    assign take_data = take && !is_ctrl;

    gfs_gen #(
        .MODULUS(MODULUS),
        .SEED_X (SEED_X),
        .SEED_Y (SEED_Y)
    ) u_gen (
        .clk    (clk),
        .rst    (rst),
        .advance(take_data),
        .key    (key),
        .busy   (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ctrl  <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= take;
            if (take) begin
                out_ctrl <= is_ctrl;
                out_word <= is_ctrl ? s.body : res_sub(in_sym, key, MOD);
            end
        end
    end
endmodule

// File: rtl/gfs_link.sv
module gfs_link
    import gfs_pkg::*;
#(
    parameter int unsigned MODULUS = 196598,
    parameter int unsigned SEED_X  = 1,
    parameter int unsigned SEED_Y  = 70001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_valid,
    output logic        tx_ready,
    input  logic        tx_ctrl,
    input  logic [15:0] tx_word,
    output logic        sym_valid,
    output logic [17:0] sym_out,
    input  logic        rx_sym_valid,
    input  logic [17:0] rx_sym,
    output logic        rx_valid,
    output logic        rx_ctrl,
    output logic [15:0] rx_word
);
    gfs_tx #(
        .MODULUS(MODULUS),
        .SEED_X (SEED_X),
        .SEED_Y (SEED_Y)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_ctrl  (tx_ctrl),
        .in_word  (tx_word),
        .in_ready (tx_ready),
        .out_valid(sym_valid),
        .out_sym  (sym_out)
    );

    gfs_rx #(
        .MODULUS(MODULUS),
        .SEED_X (SEED_X),
        .SEED_Y (SEED_Y)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_sym_valid),
        .in_sym   (rx_sym),
        .out_valid(rx_valid),
        .out_ctrl (rx_ctrl),
        .out_word (rx_word)
    );
endmodule

// File: rtl/gfs_link_chk.sv
module gfs_link_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_ctrl,
    input logic        sym_valid,
    input logic [17:0] sym_out,
    input logic        rx_sym_valid,
    input logic [17:0] rx_sym,
    input logic        rx_valid,
    input logic        rx_ctrl
);
    logic last_ctrl;

    always_ff @(posedge clk) begin
        if (rst) last_ctrl <= 1'b0;
        else if (tx_valid && tx_ready) last_ctrl <= tx_ctrl;
    end

    AST_SYM_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> sym_valid); // R7
    AST_NO_STRAY_SYM: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && tx_ready) |=> !sym_valid); // R7
    AST_DATA_HDR_FREE: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !last_ctrl) |-> (sym_out[17:16] != 2'b11 && sym_out != 18'd0)); // R4
    AST_CTRL_HDR: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && last_ctrl) |-> (sym_out[17:16] == 2'b11)); // R5
    AST_BUSY_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !tx_ctrl) |=> !tx_ready); // R6
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !tx_ready |=> tx_ready); // R6
    AST_RX_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_sym_valid |=> !rx_valid); // R8
    AST_RX_CTRL_PASS: assert property (@(posedge clk) disable iff (rst)
        (rx_sym_valid && rx_sym[17:16] == 2'b11) |=> (rx_valid && rx_ctrl)); // R9
endmodule

bind gfs_link gfs_link_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_ctrl     (tx_ctrl),
    .sym_valid   (sym_valid),
    .sym_out     (sym_out),
    .rx_sym_valid(rx_sym_valid),
    .rx_sym      (rx_sym),
    .rx_valid    (rx_valid),
    .rx_ctrl     (rx_ctrl)
);

// File: tb/gfs_link_bench.sv
`timescale 1ns/1ps
module gfs_link_bench;
    localparam int unsigned M  = 196598;
    localparam int unsigned SX = 1;
    localparam int unsigned SY = 70001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_ctrl = 1'b0;
    logic [15:0] tx_word = '0;
    logic        sym_valid;
    logic [17:0] sym_out;
    logic        rx_valid;
    logic        rx_ctrl;
    logic [15:0] rx_word;

    int n_chk  = 0;
    int n_fail = 0;
    int unsigned mx, my, mc;

    always #4 clk = ~clk;

    gfs_link #(.MODULUS(M), .SEED_X(SX), .SEED_Y(SY)) u_gfs_link (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ctrl(tx_ctrl), .tx_word(tx_word),
        .sym_valid(sym_valid), .sym_out(sym_out),
        .rx_sym_valid(sym_valid), .rx_sym(sym_out),
        .rx_valid(rx_valid), .rx_ctrl(rx_ctrl), .rx_word(rx_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned exp_sym(input int unsigned w);
        int unsigned s = w + my;
        return (s > M) ? s - M : s;
    endfunction

    task automatic model_step();
        int unsigned t = mx + my + mc;
        mx = my;
        if (t > M) begin my = t - M; mc = 1; end
        else begin my = t; mc = 0; end
    endtask

    task automatic wait_ready();
        while (!tx_ready) @(negedge clk);
    endtask

    // one data word through scrambler and descrambler
    task automatic send_data(input logic [15:0] w);
        int unsigned e;
        wait_ready();
        e = exp_sym(w);
        tx_valid = 1'b1; tx_ctrl = 1'b0; tx_word = w;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R7 sym_valid after data", sym_valid, 1);
        chk("R3 data symbol", sym_out, e);
        chk("R4 header not 11", (sym_out[17:16] == 2'b11), 0);
        chk("R4 not all zero/one", (sym_out == 18'h0 || sym_out == 18'h3FFFF), 0);
        chk("R6 ready drops", tx_ready, 0);
        model_step();
        @(negedge clk);
        chk("R7 sym_valid one cycle", sym_valid, 0);
        chk("R6 ready back", tx_ready, 1);
        chk("R8 rx_valid", rx_valid, 1);
        chk("R8 rx_ctrl low", rx_ctrl, 0);
        chk("R8 recovered word", rx_word, w);
    endtask

    task automatic send_ctrl(input logic [15:0] code);
        wait_ready();
        tx_valid = 1'b1; tx_ctrl = 1'b1; tx_word = code;
        @(negedge clk);
        tx_valid = 1'b0; tx_ctrl = 1'b0;
        chk("R5 ctrl symbol", sym_out, {2'b11, code});
        chk("R7 sym_valid ctrl", sym_valid, 1);
        chk("R6 ctrl keeps ready", tx_ready, 1);
        @(negedge clk);
        chk("R9 rx_valid ctrl", rx_valid, 1);
        chk("R9 rx_ctrl", rx_ctrl, 1);
        chk("R9 rx code", rx_word, code);
    endtask

    task automatic t_reset();
        chk("R1 ready in reset", tx_ready, 1);
        chk("R1 sym_valid in reset", sym_valid, 0);
        chk("R1 rx_valid in reset", rx_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", tx_ready, 1);
        chk("R1 sym_valid after reset", sym_valid, 0);
        chk("R1 rx_valid after reset", rx_valid, 0);
    endtask

    task automatic t_random(input int count);
        for (int i = 0; i < count; i++) send_data(16'($urandom()));
    endtask

    task automatic t_extremes();
        send_data(16'h0000);
        send_data(16'hFFFF);
        send_data(16'h0001);
        send_data(16'h8000);
    endtask

    // drive words so that word+Y hits exactly M and M+1 (R3 wrap edges)
    task automatic t_wrap_edges();
        int hits = 0;
        for (int i = 0; i < 200 && hits < 4; i++) begin
            if (my > M - 65535) begin
                if (hits[0] == 1'b0) send_data(16'(M - my));
                else send_data(16'(M - my + 1));
                hits++;
            end else begin
                send_data(16'($urandom()));
            end
        end
        chk("R3 wrap edges reached", (hits == 4), 1);
    endtask

    // control words between data: generators must not step (R5, R9, R2)
    task automatic t_ctrl_mix();
        send_data(16'h1234);
        send_ctrl(16'hA5A5);
        send_ctrl(16'h0000);
        send_data(16'h4321);
        send_ctrl(16'hFFFF);
        send_data(16'hBEEF);
    endtask

    // valid held through the busy cycle: second word waits one cycle (R6)
    task automatic t_hold_valid();
        logic [15:0] a = 16'h0F0F;
        logic [15:0] b = 16'hF0F0;
        int unsigned ea, eb;
        wait_ready();
        ea = exp_sym(a);
        tx_valid = 1'b1; tx_ctrl = 1'b0; tx_word = a;
        @(negedge clk);
        chk("R3 held first", sym_out, ea);
        model_step();
        eb = exp_sym(b);
        tx_word = b;
        @(negedge clk);
        chk("R6 busy cycle not taken", sym_valid, 0);
        chk("R8 held first recovered", rx_word, a);
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R6 taken after busy", sym_valid, 1);
        chk("R3 held second", sym_out, eb);
        model_step();
        @(negedge clk);
        chk("R8 held second recovered", rx_word, b);
    endtask

    // idle gap: no symbols, no generator step (R7, R8, R2)
    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R7 idle no symbol", sym_valid, 0);
            chk("R8 idle no rx", rx_valid, 0);
        end
        send_data(16'h5555);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        mx = SX; my = SY; mc = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_extremes();
        t_random(40);
        t_ctrl_mix();
        t_hold_valid();
        t_idle();
        t_wrap_edges();
        t_random(20);
        finish_run();
    end
endmodule